// File: doc/BRIEF.md
# Manchester Bit-Check Receive Decoder

This block sits behind a data slicer and turns an oversampled, two-level receive line into bytes. The line carries Manchester-coded cells. In each cell the line first holds the inverse of the bit value and then the bit value, so the transition in the middle of the cell carries the bit. Every interval between two line transitions is measured in clock ticks. The block sorts each interval into a single-period window or a double-period window, each bounded by a programmable minimum and maximum. Any interval that lands in neither window is rejected.

A frame opens with a preburst of identical bits. Its polarity is given on an input. The decoder waits in a search state until the first cell whose value differs from the preburst. That cell is the start bit, and it is also the most significant bit of the first byte. From then on, bits are packed MSB first, and each completed byte is announced with a one-cycle strobe. A timing violation, or a missing mid-cell transition, produces a one-cycle error pulse. The partial byte is dropped and the decoder returns to the search state. A synchronous clear does the same without the error pulse.

Top module: `manch_rx_decoder`

## Requirements
- R1: After reset, or after a clear, the decoder is in the search state and `byte_vld`, `bit_err` and `err_logic` are 0. No byte is produced until a start bit has been found.
- R2: In the search state, the start bit is found when an interval in the long window ends with the line at the level opposite to `pre_ones`: level 1 when `pre_ones`=0, level 0 when `pre_ones`=1. Short intervals, out-of-window intervals, and long intervals that end at the preburst level are ignored and raise no error.
- R3: A bit's value is the line level in the second half of its cell, so a rising mid-cell transition means 1. Bits are packed MSB first. The start bit becomes bit 7 of the first byte on `byte_data`.
- R4: An interval of n ticks between detected transitions is short when `short_min` ≤ n ≤ `short_max` and long when `long_min` ≤ n ≤ `long_max`. Short takes priority if the windows overlap. Both window edges are inclusive.
- R5: In the data state, a transition ending an interval outside both windows raises `bit_err` with `err_logic`=0.
- R6: In the data state, a long interval that follows a cell-boundary transition means a mid-cell transition is missing. It raises `bit_err` with `err_logic`=1.
- R7: In the data state, if the line stays quiet for more than `long_max` ticks, `bit_err` is raised with `err_logic`=0.
- R8: Every error discards the partial byte and returns the decoder to the search state. A byte containing an error is never strobed, and `byte_vld` and `bit_err` are never high together.
- R9: `clr` is synchronous. It discards the partial byte and returns the decoder to the search state with no error pulse. The first transition after it only starts interval timing.
- R10: `byte_vld` and `bit_err` are each single-cycle pulses. Both are registered and appear on the third rising clock edge counted from the edge that first samples the deciding line transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous return to search state |
| rx_in | input | 1 | Sliced receive line, asynchronous |
| pre_ones | input | 1 | Preburst polarity: 1 = all ones, 0 = all zeros |
| short_min | input | CNT_W | Single-period window lower limit, ticks |
| short_max | input | CNT_W | Single-period window upper limit, ticks |
| long_min | input | CNT_W | Double-period window lower limit, ticks |
| long_max | input | CNT_W | Double-period window upper limit, ticks |
| byte_data | output | BYTE_W | Last completed byte |
| byte_vld | output | 1 | One-cycle strobe for `byte_data` |
| bit_err | output | 1 | One-cycle bit error pulse |
| err_logic | output | 1 | Qualifies `bit_err`: missing mid-cell transition |

## Verification
The assertions assume that the four limits stay constant while a frame is in flight. They also assume that `short_min` is at least 1 and that the single-period window lies wholly below the double-period window. The stimulus fixes the limits once at 6/10 and 13/19 ticks and never changes them. Half-cell lengths are drawn only from a small set that includes the exact window edges and deliberate violations of 4 and 12 ticks. `clr` is pulsed only while the line is held steady, so no transition is lost to the clear.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic [1:0] {
    IV_BAD   = 2'd0,
    IV_SHORT = 2'd1,
    IV_LONG  = 2'd2
  } ivl_cls_e;

  // Sort a measured interval into a window; short wins on overlap.
  function automatic ivl_cls_e classify_ivl(input logic [15:0] n,
                                            input logic [15:0] smin,
                                            input logic [15:0] smax,
                                            input logic [15:0] lmin,
                                            input logic [15:0] lmax);
    if (n >= smin && n <= smax)      return IV_SHORT;
    else if (n >= lmin && n <= lmax) return IV_LONG;
    else                             return IV_BAD;
  endfunction

endpackage

// File: rtl/mrx_edge_sync.sv
module mrx_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic ev
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl = pipe[STAGES-1];
  assign ev  = pipe[STAGES-1] ^ pipe[STAGES];
endmodule

// File: rtl/mrx_ivl_timer.sv
module mrx_ivl_timer
  import mrx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev,
  input  logic [CNT_W-1:0] smin,
  input  logic [CNT_W-1:0] smax,
  input  logic [CNT_W-1:0] lmin,
  input  logic [CNT_W-1:0] lmax,
  output ivl_cls_e         cls,
  output logic             seen,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (ev) begin
      cnt  <= CNT_W'(1);
      seen <= 1'b1;
    end else if (cnt != CNT_TOP) begin
      cnt  <= cnt + CNT_W'(1);
    end
  end

  assign cls     = classify_ivl(16'(cnt), 16'(smin), 16'(smax), 16'(lmin), 16'(lmax));
  assign overrun = seen && (cnt > lmax);
endmodule

// File: rtl/mrx_bit_track.sv
module mrx_bit_track
  import mrx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     ev,
  input  logic     lvl,
  input  logic     seen,
  input  ivl_cls_e cls,
  input  logic     overrun,
  input  logic     pre_ones,
  output logic     hunting,
  output logic     bit_stb,
  output logic     bit_val,
  output logic     err_now,
  output logic     err_lgc
);
  logic at_mid, hunt_nx, mid_nx;

  always_comb begin
    bit_stb = 1'b0;
    bit_val = lvl;
    err_now = 1'b0;
    err_lgc = 1'b0;
    hunt_nx = hunting;
    mid_nx  = at_mid;
    if (hunting) begin
      if (ev && seen && cls == IV_LONG && lvl != pre_ones) begin
        bit_stb = 1'b1;
        hunt_nx = 1'b0;
        mid_nx  = 1'b1;
      end
    end else if (ev) begin
      unique case (cls)
        IV_SHORT: begin
          if (at_mid) mid_nx = 1'b0;
          else begin
            bit_stb = 1'b1;
            mid_nx  = 1'b1;
          end
        end
        IV_LONG: begin
          if (at_mid) bit_stb = 1'b1;
          else begin
            err_now = 1'b1;
            err_lgc = 1'b1;
          end
        end
        default: err_now = 1'b1;
      endcase
    end else if (overrun) begin
      err_now = 1'b1;
    end
    if (err_now) begin
      hunt_nx = 1'b1;
      mid_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hunting <= 1'b1;
      at_mid  <= 1'b0;
    end else if (clr) begin
      hunting <= 1'b1;
      at_mid  <= 1'b0;
    end else begin
      hunting <= hunt_nx;
      at_mid  <= mid_nx;
    end
  end
endmodule

// File: rtl/mrx_byte_pack.sv
module mrx_byte_pack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              err_now,
  input  logic              err_lgc,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              bit_err,
  output logic              err_logic
);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  nbits;
  logic [BYTE_W-1:0] shifted;

  assign shifted = {shreg[BYTE_W-2:0], bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      nbits     <= '0;
      byte_data <= '0;
      byte_vld  <= 1'b0;
      bit_err   <= 1'b0;
      err_logic <= 1'b0;
    end else begin
      byte_vld  <= 1'b0;
      bit_err   <= 1'b0;
      err_logic <= 1'b0;
      if (clr) begin
        nbits <= '0;
      end else if (err_now) begin
        nbits     <= '0;
        bit_err   <= 1'b1;
        err_logic <= err_lgc;
      end else if (bit_stb) begin
        shreg <= shifted;
        if (nbits == LAST) begin
          nbits     <= '0;
          byte_vld  <= 1'b1;
          byte_data <= shifted;
        end else begin
          nbits <= nbits + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/manch_rx_decoder.sv
module manch_rx_decoder
  import mrx_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rx_in,
  input  logic              pre_ones,
  input  logic [CNT_W-1:0]  short_min,
  input  logic [CNT_W-1:0]  short_max,
  input  logic [CNT_W-1:0]  long_min,
  input  logic [CNT_W-1:0]  long_max,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_vld,
  output logic              bit_err,
  output logic              err_logic
);
  logic     lvl, ev, seen, overrun;
  ivl_cls_e cls;
  logic     hunting, bit_stb, bit_val, err_now, err_lgc;

  mrx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_in), .lvl(lvl), .ev(ev)
  );

  mrx_ivl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev(ev),
    .smin(short_min), .smax(short_max), .lmin(long_min), .lmax(long_max),
    .cls(cls), .seen(seen), .overrun(overrun)
  );

  mrx_bit_track u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ev(ev), .lvl(lvl), .seen(seen),
    .cls(cls), .overrun(overrun), .pre_ones(pre_ones), .hunting(hunting),
    .bit_stb(bit_stb), .bit_val(bit_val), .err_now(err_now), .err_lgc(err_lgc)
  );

  mrx_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_stb(bit_stb), .bit_val(bit_val),
    .err_now(err_now), .err_lgc(err_lgc), .byte_data(byte_data),
    .byte_vld(byte_vld), .bit_err(bit_err), .err_logic(err_logic)
  );
endmodule

// File: rtl/manch_rx_decoder_chk.sv
module manch_rx_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic byte_vld,
  input logic bit_err,
  input logic err_logic,
  input logic hunting
);
  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |=> !bit_err);

  // R10
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |=> !byte_vld);

  // R6
  logic_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_logic |-> bit_err);

  // R8
  err_vld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> !byte_vld);

  // R8
  err_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> hunting);

  // R1
  hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> !hunting);

  // R9
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!bit_err && !byte_vld && hunting));
endmodule

bind manch_rx_decoder manch_rx_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .byte_vld(byte_vld),
  .bit_err(bit_err), .err_logic(err_logic), .hunting(hunting)
);

// File: tb/manch_rx_decoder_tb_top.sv
`timescale 1ns/1ps
module manch_rx_decoder_tb_top;
  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       rx_in = 1'b0;
  logic       pre_ones = 1'b0;
  logic [7:0] short_min = 8'd6, short_max = 8'd10, long_min = 8'd13, long_max = 8'd19;
  logic [7:0] byte_data;
  logic       byte_vld, bit_err, err_logic;

  always #2 clk = ~clk;

  manch_rx_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rx_in(rx_in), .pre_ones(pre_ones),
    .short_min(short_min), .short_max(short_max), .long_min(long_min),
    .long_max(long_max), .byte_data(byte_data), .byte_vld(byte_vld),
    .bit_err(bit_err), .err_logic(err_logic)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model: line history, tick count, cell phase.
  int d1, d2, d3, m_since, m_nbits, m_sh;
  bit m_seen, m_hunt, m_mid, e_vld, e_err, e_log;
  int e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = 0; d2 = 0; d3 = 0; m_since = 0; m_nbits = 0; m_sh = 0;
      m_seen = 0; m_hunt = 1; m_mid = 0; e_vld = 0; e_err = 0; e_log = 0; e_data = 0;
    end else begin
      bit tr, is_s, is_l, got, oops, lg;
      int bv;
      e_vld = 0; e_err = 0; e_log = 0;
      tr = (d2 != d3);
      if (clr) begin
        m_seen = 0; m_since = 0; m_hunt = 1; m_mid = 0; m_nbits = 0;
      end else begin
        is_s = m_since >= short_min && m_since <= short_max;
        is_l = !is_s && m_since >= long_min && m_since <= long_max;
        got = 0; oops = 0; lg = 0; bv = d2;
        if (m_hunt) begin
          if (tr && m_seen && is_l && d2 != int'(pre_ones)) begin
            got = 1; m_hunt = 0; m_mid = 1;
          end
        end else if (tr) begin
          if (is_s) begin
            if (m_mid) m_mid = 0; else begin got = 1; m_mid = 1; end
          end else if (is_l) begin
            if (m_mid) got = 1; else begin oops = 1; lg = 1; end
          end else oops = 1;
        end else if (m_since > long_max) oops = 1;
        if (oops) begin
          m_hunt = 1; m_mid = 0; m_nbits = 0; e_err = 1; e_log = lg;
        end
        if (got) begin
          m_sh = ((m_sh << 1) | bv) & 8'hFF;
          m_nbits++;
          if (m_nbits == 8) begin e_vld = 1; e_data = m_sh; m_nbits = 0; end
        end
        if (tr) begin m_seen = 1; m_since = 1; end
        else if (m_since < 255) m_since++;
      end
      d3 = d2; d2 = d1; d1 = rx_in;
    end
  end

  logic [7:0] got_q[$];
  int err_cnt = 0, log_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(byte_vld == e_vld, "R10 strobe timing", byte_vld, e_vld);
      if (e_vld) chk(byte_data == 8'(e_data), "R3 byte value", byte_data, e_data);
      chk(bit_err == e_err, "R5 error pulse", bit_err, e_err);
      chk(err_logic == e_log, "R6 logical flag", err_logic, e_log);
      if (byte_vld) got_q.push_back(byte_data);
      if (bit_err) err_cnt++;
      if (err_logic) log_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input logic v, input int len);
    rx_in = v;
    repeat (len) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int la, input int lb);
    hold(~b, la);
    hold(b, lb);
  endtask

  task automatic send_byte(input logic [7:0] v, input int la, input int lb);
    for (int i = 7; i >= 0; i--) send_bit(v[i], la, lb);
  endtask

  task automatic send_pre(input logic p, input int n, input int la, input int lb);
    for (int i = 0; i < n; i++) send_bit(p, la, lb);
  endtask

  task automatic frame_chk(input string tag, input int n, input logic [7:0] e0,
                           input logic [7:0] e1, input int e_err, input int e_lg);
    chk(got_q.size() == n, {tag, " byte count"}, got_q.size(), n);
    if (n > 0 && got_q.size() > 0) chk(got_q[0] == e0, {tag, " byte 0"}, got_q[0], e0);
    if (n > 1 && got_q.size() > 1) chk(got_q[1] == e1, {tag, " byte 1"}, got_q[1], e1);
    chk(err_cnt == e_err, {tag, " error count"}, err_cnt, e_err);
    chk(log_cnt == e_lg, {tag, " logical count"}, log_cnt, e_lg);
    got_q.delete();
    err_cnt = 0;
    log_cnt = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    chk(byte_vld == 0 && bit_err == 0 && err_logic == 0, "R1 reset outputs",
        {byte_vld, bit_err, err_logic}, 0);
    hold(0, 30);
    frame_chk("R1 idle", 0, 0, 0, 0, 0);

    // R2 R3 R7: zeros preburst with a decoy long interval ending at preburst level
    pre_ones = 1'b0;
    send_pre(0, 4, H, H);
    hold(1, 2*H); hold(0, H);
    send_pre(0, 4, H, H);
    send_byte(8'hA5, H, H);
    send_byte(8'h3C, H, H);
    hold(0, 30);
    frame_chk("R2 R3 R7 zeros preburst", 2, 8'hA5, 8'h3C, 1, 0);

    // R2: ones preburst
    pre_ones = 1'b1;
    send_pre(1, 8, H, H);
    send_byte(8'h5A, H, H);
    send_byte(8'hC3, H, H);
    hold(1, 30);
    frame_chk("R2 ones preburst", 2, 8'h5A, 8'hC3, 1, 0);

    // R5 R8: 12-tick half (between windows) mid byte
    pre_ones = 1'b0;
    send_pre(0, 8, H, H);
    send_byte(8'h81, H, H);
    send_bit(1, H, H); send_bit(0, H, H); send_bit(1, H, H); send_bit(0, H, H);
    hold(1, 12); hold(0, H);
    hold(0, 30);
    frame_chk("R5 R8 gap interval", 1, 8'h81, 0, 1, 0);
    send_pre(0, 8, H, H);
    send_byte(8'h96, H, H);
    hold(0, 30);
    frame_chk("R8 recovery", 1, 8'h96, 0, 1, 0);

    // R5: 4-tick half, below short window
    send_pre(0, 8, H, H);
    send_byte(8'h8F, H, H);
    send_bit(1, H, H); send_bit(0, H, H);
    hold(1, 4); hold(0, H);
    hold(0, 30);
    frame_chk("R5 short violation", 1, 8'h8F, 0, 1, 0);

    // R6: missing mid-cell transition
    send_pre(0, 8, H, H);
    send_byte(8'hC5, H, H);
    send_bit(1, H, H); send_bit(1, H, H); send_bit(0, H, H);
    hold(1, 2*H); hold(0, H);
    hold(0, 30);
    frame_chk("R6 missing mid edge", 1, 8'hC5, 0, 1, 1);

    // R9: clear mid byte, no error, next frame clean
    send_pre(0, 8, H, H);
    send_byte(8'hE1, H, H);
    send_bit(1, H, H); send_bit(0, H, H); send_bit(1, H, H);
    clr = 1'b1; hold(1, 1); clr = 1'b0;
    hold(1, 40);
    frame_chk("R9 after clear", 1, 8'hE1, 0, 0, 0);
    send_pre(0, 8, H, H);
    send_byte(8'hB7, H, H);
    hold(1, 30);
    frame_chk("R9 next frame", 1, 8'hB7, 0, 1, 0);

    // R4: window edges 6/7 short, 13 long
    send_pre(0, 8, 6, 7);
    send_byte(8'hB2, 6, 7);
    hold(0, 30);
    frame_chk("R4 lower edges", 1, 8'hB2, 0, 1, 0);

    // R4: window edges 10/9 short, 19 long
    send_pre(0, 8, 10, 9);
    send_byte(8'hCD, 10, 9);
    hold(1, 30);
    frame_chk("R4 upper edges", 1, 8'hCD, 0, 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule